// File: doc/BRIEF.md
# Nested-Priority Vectored Interrupt Controller

This block collects up to 32 interrupt inputs and presents a single request line to a processor. Each input slot carries a 3-bit priority, a trigger type (level or edge, either polarity) and a software-loaded vector. A word-addressed register bus lets software configure slots, turn them on and off with write-one command words, clear latched edges, and acknowledge interrupts.

Acknowledging works by reading the claim register. The read returns the vector of the winning source and pushes that source's priority onto an eight-level in-service stack. While the stack holds entries, only sources whose priority is strictly above the top entry may raise the request line. Each write to the completion register pops one level. When no source can be claimed, the claim read returns a separate fallback vector and leaves the stack unchanged.

Raw inputs pass through a two-stage synchroniser. Edge triggers compare the newest synchronised sample with the one before it.

Top module: `pvic_top`

## Requirements
- R1: After reset the request output is low, the enable mask reads 0, the claim register reads the fallback vector (reset value 0), and every mode register reads 0x20 (active-high level, priority 0).
- R2: The mode register of slot i is at word address i. Bits [2:0] hold the priority (7 is highest). Bits [5:4] hold the trigger type: 00 active-low level, 01 falling edge, 10 active-high level, 11 rising edge. Bit 3 and bits above 5 read 0.
- R3: Only slot 0 and slots from EXT_FIRST (25) upward accept the low-level and falling-edge types. On every other slot, a mode write forces trigger bit 5 to 1, so low level becomes high level and falling edge becomes rising edge.
- R4: A write to the enable word (0x42) sets the mask bits that are 1 in the data. A write to the disable word (0x43) clears them. Zero bits leave the mask unchanged. The mask reads back at 0x44. A source whose mask bit is 0 never raises the request and is never claimed.
- R5: The vector of slot i is at word address 0x20+i. A read of the claim register (0x40) returns the vector of the enabled pending source with the highest priority. When priorities are equal, the lowest slot number wins.
- R6: The fallback vector is read and written at 0x41. A claim read with no claimable source returns it.
- R7: A successful claim pushes the claimed priority onto the stack. The request output is high exactly when some enabled pending source has a priority strictly above the stack top, or has any priority when the stack is empty.
- R8: The stack is 8 levels deep. Each write to 0x46 pops one level, so eight pops after eight nested claims release the request line.
- R9: A pop write to an empty stack has no effect. A claim read while the stack is full returns the fallback vector and pushes nothing.
- R10: An edge slot latches a pending bit when two consecutive synchronised samples show the selected transition. Claiming that slot clears its latch.
- R11: A write to the clear word (0x45) clears the edge latch of every slot whose data bit is 1. Level slots are unaffected. Raw pending state reads back at 0x47.
- R12: In a level slot, the pending bit follows the synchronised input at the selected polarity and drops as soon as the input goes inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_SRC | Raw interrupt inputs, asynchronous |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Word address |
| busWData | input | DATA_W | Write data |
| busRData | output | DATA_W | Read data, combinational from the address |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The checker observes the stack depth on every cycle. It checks that the depth never exceeds eight and that a claim read made while the request is high pushes exactly one level. It also checks that a claim read made while the request is low leaves the depth unchanged, that a pop lowers a non-empty stack by one and leaves an empty one at zero, and that the request stays low while the mask is empty. The following can only be shown by the bench's scenarios: which vector wins under mixed priorities and ties, how internal slots coerce the trigger type, how edge latches set, clear and respond to claims, and the full eight-deep nest and unwind.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

  // Register word addresses (mode slots start at 0, vector slots at VEC_BASE)
  localparam int VEC_BASE   = 'h20;
  localparam int ADDR_CLAIM = 'h40;
  localparam int ADDR_SPUR  = 'h41;
  localparam int ADDR_EN    = 'h42;
  localparam int ADDR_DIS   = 'h43;
  localparam int ADDR_MASK  = 'h44;
  localparam int ADDR_CLR   = 'h45;
  localparam int ADDR_EOI   = 'h46;
  localparam int ADDR_PEND  = 'h47;

  // Trigger field: bit1 = active high / rising, bit0 = edge mode
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_HIGH = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic modeWr;
    logic vecWr;
    logic enSet;
    logic enClr;
    logic edgeClr;
    logic claim;
  } pvic_strobe_t;

endpackage

// File: rtl/pvic_datapath.sv
module pvic_datapath
  import pvic_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int PRIO_W      = 3,
  parameter int VEC_W       = 16,
  parameter int DATA_W      = 32,
  parameter int EXT_FIRST   = 25,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  pvic_strobe_t       stb,
  input  logic [IDX_W-1:0]   regIdx,
  input  logic [DATA_W-1:0]  wData,
  output logic [DATA_W-1:0]  modeRd,
  output logic [VEC_W-1:0]   vecRd,
  output logic [NUM_SRC-1:0] maskRd,
  output logic [NUM_SRC-1:0] pendRd,
  output logic               bestValid,
  output logic [PRIO_W-1:0]  bestPrio,
  output logic [VEC_W-1:0]   bestVec
);

  logic [PRIO_W-1:0]  prioReg   [NUM_SRC];
  logic [1:0]         trigReg   [NUM_SRC];
  logic [VEC_W-1:0]   vecReg    [NUM_SRC];
  logic [NUM_SRC-1:0] syncPipe  [SYNC_STAGES];
  logic [NUM_SRC-1:0] enReg, edgeLatch, edgeNext, prevLvl, syncLvl;
  logic [NUM_SRC-1:0] edgeSeen, clrHit, pending, eligible;
  logic [IDX_W-1:0]   bestIdx;

  function automatic bit slotIsExt(int i);
    return (i == 0) || (i >= EXT_FIRST);
  endfunction

  // Input synchroniser and previous-sample register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncPipe[s] <= '0;
      prevLvl <= '0;
    end else begin
      syncPipe[0] <= srcIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
      prevLvl <= syncLvl;
    end
  end
  assign syncLvl = syncPipe[SYNC_STAGES-1];

  // Per-source trigger detection and pending selection
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_comb begin
      edgeSeen[g] = trigReg[g][0] &&
                    (trigReg[g][1] ? (syncLvl[g] && !prevLvl[g])
                                   : (!syncLvl[g] && prevLvl[g]));
      clrHit[g]   = (stb.edgeClr && wData[g]) ||
                    (stb.claim && bestIdx == IDX_W'(g));
      if (!trigReg[g][0])   edgeNext[g] = 1'b0;
      else if (edgeSeen[g]) edgeNext[g] = 1'b1;
      else if (clrHit[g])   edgeNext[g] = 1'b0;
      else                  edgeNext[g] = edgeLatch[g];
      pending[g] = trigReg[g][0] ? edgeLatch[g]
                                 : (trigReg[g][1] ? syncLvl[g] : !syncLvl[g]);
    end
  end

  assign eligible = pending & enReg;

  // Configuration registers, enable mask and edge latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        prioReg[i] <= '0;
        trigReg[i] <= TRIG_HIGH;
        vecReg[i]  <= '0;
      end
      enReg     <= '0;
      edgeLatch <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (stb.modeWr && regIdx == IDX_W'(i)) begin
          prioReg[i] <= wData[PRIO_W-1:0];
          trigReg[i] <= slotIsExt(i) ? wData[5:4] : {1'b1, wData[4]};
        end
        if (stb.vecWr && regIdx == IDX_W'(i)) vecReg[i] <= wData[VEC_W-1:0];
      end
      if (stb.enSet)      enReg <= enReg | wData[NUM_SRC-1:0];
      else if (stb.enClr) enReg <= enReg & ~wData[NUM_SRC-1:0];
      edgeLatch <= edgeNext;
    end
  end

  // Arbitration: highest priority, ties to lowest index (scan downward)
  always_comb begin
    bestValid = 1'b0;
    bestPrio  = '0;
    bestIdx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i] && (!bestValid || prioReg[i] >= bestPrio)) begin
        bestValid = 1'b1;
        bestPrio  = prioReg[i];
        bestIdx   = IDX_W'(i);
      end
    end
  end

  assign bestVec = vecReg[bestIdx];
  assign modeRd  = DATA_W'({trigReg[regIdx], 1'b0, prioReg[regIdx]});
  assign vecRd   = vecReg[regIdx];
  assign maskRd  = enReg;
  assign pendRd  = pending;

endmodule

// File: rtl/pvic_control.sv
module pvic_control
  import pvic_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int PRIO_W      = 3,
  parameter int VEC_W       = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 7,
  parameter int STACK_DEPTH = 8,
  parameter int IDX_W       = $clog2(NUM_SRC),
  parameter int DEPTH_W     = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWData,
  output logic [DATA_W-1:0]  busRData,
  output logic               irqOut,
  output pvic_strobe_t       stb,
  output logic [IDX_W-1:0]   regIdx,
  output logic [DEPTH_W-1:0] depth,
  input  logic [DATA_W-1:0]  modeRd,
  input  logic [VEC_W-1:0]   vecRd,
  input  logic [NUM_SRC-1:0] maskRd,
  input  logic [NUM_SRC-1:0] pendRd,
  input  logic               bestValid,
  input  logic [PRIO_W-1:0]  bestPrio,
  input  logic [VEC_W-1:0]   bestVec
);

  localparam int SP_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam logic [ADDR_W-1:0] A_VEC   = ADDR_W'(VEC_BASE);
  localparam logic [ADDR_W-1:0] A_VEND  = ADDR_W'(VEC_BASE + NUM_SRC);
  localparam logic [ADDR_W-1:0] A_NSRC  = ADDR_W'(NUM_SRC);
  localparam logic [ADDR_W-1:0] A_CLAIM = ADDR_W'(ADDR_CLAIM);
  localparam logic [ADDR_W-1:0] A_SPUR  = ADDR_W'(ADDR_SPUR);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(ADDR_EN);
  localparam logic [ADDR_W-1:0] A_DIS   = ADDR_W'(ADDR_DIS);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(ADDR_MASK);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(ADDR_CLR);
  localparam logic [ADDR_W-1:0] A_EOI   = ADDR_W'(ADDR_EOI);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(ADDR_PEND);

  logic [PRIO_W-1:0] stackMem [STACK_DEPTH];
  logic [PRIO_W-1:0] topPrio;
  logic [VEC_W-1:0]  spurVec;
  logic              wrAcc, rdAcc, isMode, isVec, claimable, popStb;
  logic [DATA_W-1:0] wDataUnused;

  assign wDataUnused = busWData;
  assign wrAcc  = busSel && busWr;
  assign rdAcc  = busSel && !busWr;
  assign isMode = busAddr < A_NSRC;
  assign isVec  = (busAddr >= A_VEC) && (busAddr < A_VEND);
  assign regIdx = isVec ? IDX_W'(busAddr - A_VEC) : IDX_W'(busAddr);

  // Nesting comparison against the top of the in-service stack
  assign topPrio   = stackMem[SP_W'(depth - 1'b1)];
  assign claimable = bestValid && (depth < DEPTH_W'(STACK_DEPTH)) &&
                     ((depth == '0) || (bestPrio > topPrio));
  assign irqOut    = claimable;

  always_comb begin
    stb         = '0;
    stb.modeWr  = wrAcc && isMode;
    stb.vecWr   = wrAcc && isVec;
    stb.enSet   = wrAcc && busAddr == A_EN;
    stb.enClr   = wrAcc && busAddr == A_DIS;
    stb.edgeClr = wrAcc && busAddr == A_CLR;
    stb.claim   = rdAcc && busAddr == A_CLAIM && claimable;
  end
  assign popStb = wrAcc && busAddr == A_EOI;

  // Stack depth and fallback vector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth   <= '0;
      spurVec <= '0;
    end else begin
      if (stb.claim)                depth <= depth + 1'b1;
      else if (popStb && depth != 0) depth <= depth - 1'b1;
      if (wrAcc && busAddr == A_SPUR) spurVec <= busWData[VEC_W-1:0];
    end
  end

  // Stack storage (no reset needed: entries are only read below depth)
  always_ff @(posedge clk) begin
    if (stb.claim) stackMem[SP_W'(depth)] <= bestPrio;
  end

  // Read mux
  always_comb begin
    busRData = '0;
    if (isMode)     busRData = modeRd;
    else if (isVec) busRData = DATA_W'(vecRd);
    else begin
      case (busAddr)
        A_CLAIM: busRData = DATA_W'(claimable ? bestVec : spurVec);
        A_SPUR:  busRData = DATA_W'(spurVec);
        A_MASK:  busRData = DATA_W'(maskRd);
        A_PEND:  busRData = DATA_W'(pendRd);
        default: busRData = '0;
      endcase
    end
  end

endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int PRIO_W      = 3,
  parameter int VEC_W       = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 7,
  parameter int STACK_DEPTH = 8,
  parameter int EXT_FIRST   = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWData,
  output logic [DATA_W-1:0]  busRData,
  output logic               irqOut
);

  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int DEPTH_W = $clog2(STACK_DEPTH + 1);

  pvic_strobe_t       stb;
  logic [IDX_W-1:0]   regIdx;
  logic [DEPTH_W-1:0] stackDepth;
  logic [DATA_W-1:0]  modeRd;
  logic [VEC_W-1:0]   vecRd, bestVec;
  logic [NUM_SRC-1:0] maskRd, pendRd;
  logic               bestValid;
  logic [PRIO_W-1:0]  bestPrio;

  pvic_control #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .STACK_DEPTH(STACK_DEPTH), .IDX_W(IDX_W), .DEPTH_W(DEPTH_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .irqOut(irqOut), .stb(stb),
    .regIdx(regIdx), .depth(stackDepth), .modeRd(modeRd), .vecRd(vecRd),
    .maskRd(maskRd), .pendRd(pendRd), .bestValid(bestValid),
    .bestPrio(bestPrio), .bestVec(bestVec)
  );

  pvic_datapath #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .DATA_W(DATA_W),
    .EXT_FIRST(EXT_FIRST), .SYNC_STAGES(SYNC_STAGES), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .stb(stb), .regIdx(regIdx),
    .wData(busWData), .modeRd(modeRd), .vecRd(vecRd), .maskRd(maskRd),
    .pendRd(pendRd), .bestValid(bestValid), .bestPrio(bestPrio),
    .bestVec(bestVec)
  );

endmodule

// File: rtl/pvic_checker.sv
module pvic_checker
  import pvic_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int ADDR_W      = 7,
  parameter int STACK_DEPTH = 8,
  parameter int DEPTH_W     = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWr,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               irqOut,
  input logic [DEPTH_W-1:0] stackDepth,
  input logic [NUM_SRC-1:0] maskRd
);

  logic claimRd, popWr;
  assign claimRd = busSel && !busWr && busAddr == ADDR_W'(ADDR_CLAIM);
  assign popWr   = busSel && busWr && busAddr == ADDR_W'(ADDR_EOI);

  // R8: depth bounded by the stack size
  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    stackDepth <= DEPTH_W'(STACK_DEPTH));

  // R7: a claim while requesting pushes one level
  assert_claim_push_R7: assert property (@(posedge clk) disable iff (!rstN)
    claimRd && irqOut |=> stackDepth == DEPTH_W'($past(stackDepth) + 1'b1));

  // R6 / R9: a claim with no request pushes nothing
  assert_spurious_nopush_R6: assert property (@(posedge clk) disable iff (!rstN)
    claimRd && !irqOut |=> $stable(stackDepth));

  // R8: completion pops one level from a non-empty stack
  assert_pop_one_R8: assert property (@(posedge clk) disable iff (!rstN)
    popWr && stackDepth != '0 |=> stackDepth == DEPTH_W'($past(stackDepth) - 1'b1));

  // R9: completion on an empty stack is ignored
  assert_pop_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    popWr && stackDepth == '0 |=> stackDepth == '0);

  // R4: nothing enabled means no request
  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    maskRd == '0 |-> !irqOut);

endmodule

bind pvic_top pvic_checker #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .STACK_DEPTH(STACK_DEPTH), .DEPTH_W(DEPTH_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .irqOut(irqOut), .stackDepth(stackDepth), .maskRd(maskRd)
);

// File: tb/sim_pvic_top.sv
`timescale 1ns/1ps
module sim_pvic_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [6:0]  busAddr = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        irqOut;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pvic_top u0 (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData), .irqOut(irqOut)
  );

  localparam logic [6:0] A_CLAIM = 7'h40, A_SPUR = 7'h41, A_EN = 7'h42,
                         A_DIS = 7'h43, A_MASK = 7'h44, A_CLR = 7'h45,
                         A_EOI = 7'h46, A_PEND = 7'h47;
  localparam int EXT_FIRST = 25;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #2 d = busRData;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic setInputs(input logic [31:0] v);
    @(negedge clk);
    srcIn = v;
    repeat (4) @(negedge clk);
  endtask

  function automatic int prioOf(int i);
    return (i * 3) % 8;
  endfunction

  function automatic int winnerOf(logic [31:0] elig);
    int best = -1;
    for (int i = 0; i < 32; i++)
      if (elig[i] && (best < 0 || prioOf(i) > prioOf(best))) best = i;
    return best;
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, pat, x, enMask, acc;
    int w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    chk("R1 irq", {31'b0, irqOut}, 32'h0);
    busRead(A_MASK, rd);  chk("R1 mask", rd, 32'h0);
    busRead(A_CLAIM, rd); chk("R1 claim", rd, 32'h0);
    busRead(7'h07, rd);   chk("R1 mode", rd, 32'h20);

    // R2 / R3: trigger field per slot, internal slots coerced
    for (int i = 0; i < 32; i++) begin
      for (int t = 0; t < 4; t++) begin
        int et;
        busWrite(7'(i), 32'((t << 4) | (i % 8)));
        busRead(7'(i), rd);
        et = (i == 0 || i >= EXT_FIRST) ? t : (t | 2);
        chk((i == 0 || i >= EXT_FIRST) ? "R2 mode" : "R3 coerce", rd, 32'((et << 4) | (i % 8)));
      end
    end

    // Configure: high level, priority (i*3)%8, vector 0x100+i
    for (int i = 0; i < 32; i++) begin
      busWrite(7'(i), 32'(32'h20 | prioOf(i)));
      busWrite(7'(32 + i), 32'(32'h100 + i));
    end
    busRead(7'h25, rd); chk("R5 vecreg", rd, 32'h105);

    // R4: enable / disable command words
    busWrite(A_EN, 32'hA5A5A5A5);  busRead(A_MASK, rd); chk("R4 en", rd, 32'hA5A5A5A5);
    busWrite(A_DIS, 32'h0F0F0F0F); busRead(A_MASK, rd); chk("R4 dis", rd, 32'hA0A0A0A0);
    busWrite(A_EN, 32'h00000001);  busRead(A_MASK, rd); chk("R4 en0", rd, 32'hA0A0A0A1);
    busWrite(A_EN, 32'hFFFFFFFF);
    busWrite(A_DIS, 32'h00800010);
    enMask = ~32'h00800010;
    busRead(A_MASK, rd); chk("R4 mask", rd, enMask);

    // R6: fallback vector
    busWrite(A_SPUR, 32'h0000BEEF);
    busRead(A_SPUR, rd);  chk("R6 spur", rd, 32'hBEEF);
    busRead(A_CLAIM, rd); chk("R6 none", rd, 32'hBEEF);

    // R4: disabled pending source is neither requested nor claimed
    setInputs(32'h00000010);
    chk("R4 noirq", {31'b0, irqOut}, 32'h0);
    busRead(A_CLAIM, rd); chk("R4 noclaim", rd, 32'hBEEF);

    // R5 / R7: arbitration sweep over pseudo-random patterns
    x = 32'h1234_5678;
    for (int k = 0; k < 48; k++) begin
      logic [31:0] y;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      y = x ^ (x << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
      pat = (k == 0) ? 32'h0 : (k < 4 ? (x | y) : (x & y));
      setInputs(pat);
      w = winnerOf(pat & enMask);
      chk("R7 irq", {31'b0, irqOut}, {31'b0, w >= 0});
      busRead(A_CLAIM, rd);
      chk("R5 claim", rd, (w >= 0) ? 32'(32'h100 + w) : 32'hBEEF);
      if (w >= 0) busWrite(A_EOI, 32'h0);
    end

    // R7 / R8 / R9: eight-deep nesting, full-stack claim, unwind
    setInputs(32'h0);
    busWrite(A_EN, 32'hFFFFFFFF);
    for (int p = 0; p < 8; p++) busWrite(7'(8 + p), 32'(32'h20 | p));
    acc = '0;
    for (int p = 0; p < 8; p++) begin
      acc[8 + p] = 1'b1;
      setInputs(acc);
      chk("R7 raise", {31'b0, irqOut}, 32'h1);
      busRead(A_CLAIM, rd); chk("R7 nest", rd, 32'(32'h108 + p));
      @(negedge clk);
      chk("R7 held", {31'b0, irqOut}, 32'h0);
    end
    busRead(A_CLAIM, rd); chk("R9 full", rd, 32'hBEEF);
    setInputs(32'h00000100);
    for (int k = 1; k <= 7; k++) begin
      busWrite(A_EOI, 32'h0);
      chk("R8 unwind", {31'b0, irqOut}, 32'h0);
    end
    busWrite(A_EOI, 32'h0);
    chk("R8 release", {31'b0, irqOut}, 32'h1);
    busWrite(A_EOI, 32'h0);
    busRead(A_CLAIM, rd); chk("R9 emptypop", rd, 32'h108);
    @(negedge clk);
    chk("R9 depth", {31'b0, irqOut}, 32'h0);
    busWrite(A_EOI, 32'h0);
    setInputs(32'h0);

    // R10 / R11: falling edge on external slot 26
    busWrite(7'd26, 32'h12);
    setInputs(32'h04000000);
    busRead(A_PEND, rd); chk("R10 norise", rd & 32'h04000000, 32'h0);
    setInputs(32'h0);
    busRead(A_PEND, rd); chk("R10 fall", rd & 32'h04000000, 32'h04000000);
    chk("R10 irq", {31'b0, irqOut}, 32'h1);
    busWrite(A_CLR, 32'h04000000);
    busRead(A_PEND, rd); chk("R11 clr", rd & 32'h04000000, 32'h0);
    chk("R11 irq", {31'b0, irqOut}, 32'h0);
    setInputs(32'h04000000);
    setInputs(32'h0);
    busRead(A_CLAIM, rd); chk("R10 claim", rd, 32'h11A);
    busRead(A_PEND, rd); chk("R10 claimclr", rd & 32'h04000000, 32'h0);
    busWrite(A_EOI, 32'h0);

    // R10: rising edge on internal slot 5 stays latched
    busWrite(7'd5, 32'h33);
    setInputs(32'h00000020);
    setInputs(32'h0);
    busRead(A_PEND, rd); chk("R10 rise", rd & 32'h20, 32'h20);
    busWrite(A_CLR, 32'h00000020);
    busRead(A_PEND, rd); chk("R11 clr5", rd & 32'h20, 32'h0);

    // R11 / R12: level slots ignore clear and track input
    setInputs(32'h00000008);
    busWrite(A_CLR, 32'h00000008);
    busRead(A_PEND, rd); chk("R11 level", rd & 32'h8, 32'h8);
    setInputs(32'h0);
    busRead(A_PEND, rd); chk("R12 drop", rd & 32'h8, 32'h0);
    busWrite(7'd0, 32'h01);
    busRead(A_PEND, rd); chk("R12 lowact", rd & 32'h1, 32'h1);
    setInputs(32'h00000001);
    busRead(A_PEND, rd); chk("R12 lowidle", rd & 32'h1, 32'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule